// File: doc/BRIEF.md
# Pre-fetching Register Wrapper for a Task Core

This block sits between a simple system bus (address, write data, read strobe, write strobe) and the internal register port of a task-style core. The core holds three 8-bit registers: a data-input register that starts a task when written, a data-output register that holds the result, and a status register whose done flag reports task completion. The system bus reaches these registers only through the wrapper.

Every system write is forwarded to the core one cycle later. A write to the data-input register also starts a pre-fetch sequence. The wrapper polls the status register until the done flag is set, then reads the data-output register. Both values are kept in local copies. A system read of status or data output is answered from a valid copy with no wait cycles. If the copy is not valid, the wrapper falls back to a pass-through read and holds a wait signal until the core answers. A parameter removes the pre-fetch unit, so the same wrapper can be compared with and without it.

Top module: `pf_bus_wrapper`

## Requirements
- R1: While reset is high and in the first cycle after it, `bus_ack`, `bus_wait`, `core_rd` and `core_wr` are all low.
- R2: With pre-fetch enabled, a read of status (address 2) or data output (address 1) whose copy is valid is acknowledged in the cycle after the request, with the copied value. `bus_wait` stays low and no core access is made.
- R3: A read that cannot use a copy drives `core_rd` with the requested address in the cycle after the request. `bus_wait` is high for two cycles, and `bus_ack` comes in the third cycle after the request, carrying the core's value.
- R4: A system write appears on `core_wr`, `core_addr` and `core_wdata` in the cycle after the request, and is acknowledged in that same cycle.
- R5: After a write to data input (address 0), the wrapper reads status until bit 0 (done) is 1, then reads data output. Once the task completes, both copies hold the core's final values.
- R6: A write to data input invalidates both copies in the same clock edge. A status or data-output read issued right after that write is served by pass-through, and never from a copy left over from the previous task.
- R7: System accesses take the core port ahead of pending pre-fetch reads. A system write issued while polling is in progress is forwarded in the very next cycle. `core_rd` and `core_wr` are never high together.
- R8: With pre-fetch disabled, every core read follows a system read request, and every status or data-output read takes the pass-through timing of R3. It returns the same data the enabled variant returns.
- R9: A read of data input (address 0) is always a pass-through read with the timing of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | System register address |
| bus_wdata | input | DW | System write data |
| bus_rd | input | 1 | System read request, one cycle |
| bus_wr | input | 1 | System write request, one cycle |
| bus_rdata | output | DW | Read data, valid with bus_ack |
| bus_ack | output | 1 | Access complete, one cycle pulse |
| bus_wait | output | 1 | Pass-through read in progress |
| core_addr | output | AW | Core register address |
| core_wdata | output | DW | Core write data |
| core_rd | output | 1 | Core read strobe |
| core_wr | output | 1 | Core write strobe |
| core_rdata | input | DW | Core read data, one cycle after core_rd |

## Verification
The assertions check, on every cycle, the properties that can be seen at a single edge or pair of edges. These are the forwarding of writes, the one-cycle answer or start of waiting after each read, the end of every two-cycle wait, invalidation of both copies on a data-input write, the exclusion of simultaneous core read and write, and, without pre-fetch, that every core read follows a bus read. Only the bench scenarios can show the outcomes that depend on a whole task. These are that settled status and result reads hit with the correct values and touch no core port, that a read right after a task start returns the fresh busy status, and that interrupted back-to-back tasks never leak old results. They also show the total read latency saved relative to the variant without pre-fetch.

// File: rtl/pfw_pkg.sv
package pfw_pkg;
  typedef enum logic [2:0] {
    PF_IDLE,
    PF_POLL,
    PF_WAIT_S,
    PF_FETCH,
    PF_WAIT_D
  } pf_state_t;
endpackage

// File: rtl/pfw_bus_ctrl.sv
module pfw_bus_ctrl #(
  parameter int AW       = 2,
  parameter int DW       = 8,
  parameter int ADDR_DI  = 0,
  parameter int ADDR_DO  = 1,
  parameter int ADDR_ST  = 2,
  parameter bit PF_EN    = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] st_shadow,
  input  logic          st_valid,
  input  logic [DW-1:0] do_shadow,
  input  logic          do_valid,
  input  logic          ret_valid,
  input  logic          ret_bus,
  input  logic [DW-1:0] ret_data,
  output logic          port_rd,
  output logic          port_wr,
  output logic          di_write,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_ack,
  output logic          bus_wait
);
  localparam logic [AW-1:0] A_DI = AW'(ADDR_DI);
  localparam logic [AW-1:0] A_DO = AW'(ADDR_DO);
  localparam logic [AW-1:0] A_ST = AW'(ADDR_ST);

  logic sel_di, sel_do, sel_st, hit;

  always_comb begin
    sel_di   = (bus_addr == A_DI);
    sel_do   = (bus_addr == A_DO);
    sel_st   = (bus_addr == A_ST);
    hit      = PF_EN && ((sel_st && st_valid) || (sel_do && do_valid));
    port_rd  = bus_rd && !hit;
    port_wr  = bus_wr;
    di_write = bus_wr && sel_di;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack   <= 1'b0;
      bus_wait  <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack <= 1'b0;
      if (bus_wr) begin
        bus_ack <= 1'b1;
      end else if (bus_rd && hit) begin
        bus_ack   <= 1'b1;
        bus_rdata <= sel_st ? st_shadow : do_shadow;
      end else if (bus_rd) begin
        bus_wait <= 1'b1;
      end
      if (ret_valid && ret_bus) begin
        bus_ack   <= 1'b1;
        bus_wait  <= 1'b0;
        bus_rdata <= ret_data;
      end
    end
  end
endmodule

// File: rtl/pfw_port_arb.sv
module pfw_port_arb #(
  parameter int AW = 2,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr_req,
  input  logic          bus_rd_req,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          pf_req,
  input  logic [AW-1:0] pf_addr,
  input  logic          di_write,
  output logic          pf_grant,
  output logic [AW-1:0] core_addr,
  output logic [DW-1:0] core_wdata,
  output logic          core_rd,
  output logic          core_wr,
  output logic          ret_valid,
  output logic          ret_bus,
  output logic          ret_pf
);
  logic issue_bus, issue_pf, bus_any;

  always_comb begin
    bus_any  = bus_wr_req || bus_rd_req;
    pf_grant = pf_req && !bus_any;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      core_rd    <= 1'b0;
      core_wr    <= 1'b0;
      core_addr  <= '0;
      core_wdata <= '0;
      issue_bus  <= 1'b0;
      issue_pf   <= 1'b0;
      ret_valid  <= 1'b0;
      ret_bus    <= 1'b0;
      ret_pf     <= 1'b0;
    end else begin
      core_wr   <= bus_wr_req;
      core_rd   <= (bus_rd_req && !bus_wr_req) || pf_grant;
      issue_bus <= bus_rd_req && !bus_wr_req;
      issue_pf  <= pf_grant;
      if (bus_any) core_addr <= bus_addr;
      else if (pf_grant) core_addr <= pf_addr;
      if (bus_wr_req) core_wdata <= bus_wdata;
      ret_valid <= core_rd;
      ret_bus   <= core_rd && issue_bus;
      ret_pf    <= core_rd && issue_pf && !di_write;
    end
  end
endmodule

// File: rtl/pfw_prefetch.sv
module pfw_prefetch #(
  parameter int AW       = 2,
  parameter int DW       = 8,
  parameter int ADDR_DO  = 1,
  parameter int ADDR_ST  = 2,
  parameter int DONE_BIT = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          di_write,
  input  logic          pf_grant,
  input  logic          ret_pf,
  input  logic [DW-1:0] ret_data,
  output logic          pf_req,
  output logic [AW-1:0] pf_addr,
  output logic [DW-1:0] st_shadow,
  output logic          st_valid,
  output logic [DW-1:0] do_shadow,
  output logic          do_valid
);
  import pfw_pkg::*;

  pf_state_t state;

  always_comb begin
    pf_req  = (state == PF_POLL) || (state == PF_FETCH);
    pf_addr = (state == PF_FETCH) ? AW'(ADDR_DO) : AW'(ADDR_ST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PF_IDLE;
      st_shadow <= '0;
      st_valid  <= 1'b0;
      do_shadow <= '0;
      do_valid  <= 1'b0;
    end else if (di_write) begin
      state    <= PF_POLL;
      st_valid <= 1'b0;
      do_valid <= 1'b0;
    end else begin
      case (state)
        PF_POLL:   if (pf_grant) state <= PF_WAIT_S;
        PF_WAIT_S: if (ret_pf) begin
                     st_shadow <= ret_data;
                     st_valid  <= 1'b1;
                     state     <= ret_data[DONE_BIT] ? PF_FETCH : PF_POLL;
                   end
        PF_FETCH:  if (pf_grant) state <= PF_WAIT_D;
        PF_WAIT_D: if (ret_pf) begin
                     do_shadow <= ret_data;
                     do_valid  <= 1'b1;
                     state     <= PF_IDLE;
                   end
        default:   state <= PF_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pf_bus_wrapper.sv
module pf_bus_wrapper #(
  parameter int AW       = 2,
  parameter int DW       = 8,
  parameter int ADDR_DI  = 0,
  parameter int ADDR_DO  = 1,
  parameter int ADDR_ST  = 2,
  parameter int DONE_BIT = 0,
  parameter bit PF_EN    = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_rd,
  input  logic          bus_wr,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_ack,
  output logic          bus_wait,
  output logic [AW-1:0] core_addr,
  output logic [DW-1:0] core_wdata,
  output logic          core_rd,
  output logic          core_wr,
  input  logic [DW-1:0] core_rdata
);
  logic          port_rd, port_wr, di_write;
  logic          pf_req, pf_grant;
  logic [AW-1:0] pf_addr;
  logic          ret_valid, ret_bus, ret_pf;
  logic [DW-1:0] st_shadow, do_shadow;
  logic          st_valid, do_valid;

  pfw_bus_ctrl #(
    .AW(AW), .DW(DW), .ADDR_DI(ADDR_DI), .ADDR_DO(ADDR_DO),
    .ADDR_ST(ADDR_ST), .PF_EN(PF_EN)
  ) u_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .st_shadow(st_shadow), .st_valid(st_valid),
    .do_shadow(do_shadow), .do_valid(do_valid), .ret_valid(ret_valid),
    .ret_bus(ret_bus), .ret_data(core_rdata), .port_rd(port_rd),
    .port_wr(port_wr), .di_write(di_write), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .bus_wait(bus_wait)
  );

  pfw_port_arb #(.AW(AW), .DW(DW)) u_arb (
    .clk(clk), .rst(rst), .bus_wr_req(port_wr), .bus_rd_req(port_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pf_req(pf_req),
    .pf_addr(pf_addr), .di_write(di_write), .pf_grant(pf_grant),
    .core_addr(core_addr), .core_wdata(core_wdata), .core_rd(core_rd),
    .core_wr(core_wr), .ret_valid(ret_valid), .ret_bus(ret_bus),
    .ret_pf(ret_pf)
  );

  generate
    if (PF_EN) begin : g_pf
      pfw_prefetch #(
        .AW(AW), .DW(DW), .ADDR_DO(ADDR_DO), .ADDR_ST(ADDR_ST),
        .DONE_BIT(DONE_BIT)
      ) u_pf (
        .clk(clk), .rst(rst), .di_write(di_write), .pf_grant(pf_grant),
        .ret_pf(ret_pf), .ret_data(core_rdata), .pf_req(pf_req),
        .pf_addr(pf_addr), .st_shadow(st_shadow), .st_valid(st_valid),
        .do_shadow(do_shadow), .do_valid(do_valid)
      );
    end else begin : g_nopf
      assign pf_req    = 1'b0;
      assign pf_addr   = '0;
      assign st_shadow = '0;
      assign st_valid  = 1'b0;
      assign do_shadow = '0;
      assign do_valid  = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/pfw_checker.sv
module pfw_checker #(
  parameter int AW      = 2,
  parameter int DW      = 8,
  parameter int ADDR_DI = 0,
  parameter bit PF_EN   = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          bus_ack,
  input logic          bus_wait,
  input logic [AW-1:0] core_addr,
  input logic [DW-1:0] core_wdata,
  input logic          core_rd,
  input logic          core_wr,
  input logic          st_valid,
  input logic          do_valid
);
  logic rst_q = 1'b0;
  always @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q && !rst)
      assert_reset_quiet_R1: assert (!bus_ack && !bus_wait && !core_rd && !core_wr);
  end

  assert_answer_or_wait_R2: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> (bus_ack ^ bus_wait));

  assert_wait_ends_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wait && $past(bus_wait)) |=> (bus_ack && !bus_wait));

  assert_write_fwd_R4: assert property (@(posedge clk) disable iff (rst)
    bus_wr |=> (core_wr && core_addr == $past(bus_addr) && core_wdata == $past(bus_wdata)));

  assert_stale_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(ADDR_DI)) |=> (!st_valid && !do_valid));

  assert_port_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(core_rd && core_wr));

  assert_nopf_reads_R8: assert property (@(posedge clk) disable iff (rst)
    (!PF_EN && core_rd) |-> $past(bus_rd));

  assert_di_passthru_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == AW'(ADDR_DI)) |=> (core_rd && bus_wait && core_addr == AW'(ADDR_DI)));
endmodule

bind pf_bus_wrapper pfw_checker #(
  .AW(AW), .DW(DW), .ADDR_DI(ADDR_DI), .PF_EN(PF_EN)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ack(bus_ack), .bus_wait(bus_wait),
  .core_addr(core_addr), .core_wdata(core_wdata), .core_rd(core_rd),
  .core_wr(core_wr), .st_valid(st_valid), .do_valid(do_valid)
);

// File: tb/pf_bus_wrapper_bench.sv
module pfw_core_model (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] lat,
  input  logic [1:0] c_addr,
  input  logic [7:0] c_wdata,
  input  logic       c_rd,
  input  logic       c_wr,
  output logic [7:0] c_rdata
);
  logic [7:0] di, dor, st, cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      di <= '0; dor <= '0; st <= '0; cnt <= '0; c_rdata <= '0;
    end else begin
      if (c_rd)
        c_rdata <= (c_addr == 2'd0) ? di : (c_addr == 2'd1) ? dor :
                   (c_addr == 2'd2) ? st : 8'h00;
      if (c_wr && c_addr == 2'd0) begin
        di <= c_wdata; st <= 8'h00; cnt <= lat;
      end else if (cnt != 0) begin
        cnt <= cnt - 8'd1;
        if (cnt == 8'd1) begin
          dor <= {di[3:0], di[7:4]} ^ 8'h3C;
          st  <= 8'h01;
        end
      end
    end
  end
endmodule

module pf_bus_wrapper_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [1:0] b_addr [2];
  logic [7:0] b_wdata [2];
  logic       b_rd [2];
  logic       b_wr [2];
  logic [7:0] b_rdata [2];
  logic       b_ack [2];
  logic       b_wait [2];
  logic [1:0] c_addr [2];
  logic [7:0] c_wdata [2];
  logic       c_rd [2];
  logic       c_wr [2];
  logic [7:0] c_rdata [2];
  logic [7:0] lat [2];
  int rdcnt [2];
  int total = 0;
  int bad = 0;
  int lat_sum [2];

  pf_bus_wrapper #(.PF_EN(1'b1)) u_pf_bus_wrapper (
    .clk(clk), .rst(rst), .bus_addr(b_addr[0]), .bus_wdata(b_wdata[0]),
    .bus_rd(b_rd[0]), .bus_wr(b_wr[0]), .bus_rdata(b_rdata[0]),
    .bus_ack(b_ack[0]), .bus_wait(b_wait[0]), .core_addr(c_addr[0]),
    .core_wdata(c_wdata[0]), .core_rd(c_rd[0]), .core_wr(c_wr[0]),
    .core_rdata(c_rdata[0]));
  pfw_core_model u_core0 (.clk(clk), .rst(rst), .lat(lat[0]), .c_addr(c_addr[0]),
    .c_wdata(c_wdata[0]), .c_rd(c_rd[0]), .c_wr(c_wr[0]), .c_rdata(c_rdata[0]));

  pf_bus_wrapper #(.PF_EN(1'b0)) u_pf_bus_wrapper_nopf (
    .clk(clk), .rst(rst), .bus_addr(b_addr[1]), .bus_wdata(b_wdata[1]),
    .bus_rd(b_rd[1]), .bus_wr(b_wr[1]), .bus_rdata(b_rdata[1]),
    .bus_ack(b_ack[1]), .bus_wait(b_wait[1]), .core_addr(c_addr[1]),
    .core_wdata(c_wdata[1]), .core_rd(c_rd[1]), .core_wr(c_wr[1]),
    .core_rdata(c_rdata[1]));
  pfw_core_model u_core1 (.clk(clk), .rst(rst), .lat(lat[1]), .c_addr(c_addr[1]),
    .c_wdata(c_wdata[1]), .c_rd(c_rd[1]), .c_wr(c_wr[1]), .c_rdata(c_rdata[1]));

  always @(posedge clk) begin
    if (c_rd[0]) rdcnt[0] <= rdcnt[0] + 1;
    if (c_rd[1]) rdcnt[1] <= rdcnt[1] + 1;
  end

  function automatic logic [7:0] exp_result(logic [7:0] d);
    return {d[3:0], d[7:4]} ^ 8'h3C;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(int u, logic [1:0] a, logic [7:0] d, string req);
    @(negedge clk);
    b_wr[u] = 1'b1; b_addr[u] = a; b_wdata[u] = d;
    @(negedge clk);
    b_wr[u] = 1'b0;
    chk(b_ack[u] == 1'b1, {req, " write ack"}, int'(b_ack[u]), 1);
    chk(c_wr[u] && c_addr[u] == a && c_wdata[u] == d, {req, " write forwarded"},
        int'(c_wdata[u]), int'(d));
  endtask

  task automatic bus_read(int u, logic [1:0] a, output logic [7:0] d, output int n);
    @(negedge clk);
    b_rd[u] = 1'b1; b_addr[u] = a;
    @(negedge clk);
    b_rd[u] = 1'b0;
    n = 1;
    while (!b_ack[u] && n < 40) begin
      @(negedge clk);
      n++;
    end
    d = b_rdata[u];
  endtask

  task automatic run_unit(int u);
    logic [7:0] d, v;
    int n, r0, hit_n;
    hit_n = (u == 0) ? 1 : 3;
    // R3: data output before any task, no copy valid
    bus_read(u, 2'd1, v, n);
    chk(n == 3, "R3 miss latency", n, 3);
    chk(v == 8'h00, "R3 miss data", int'(v), 0);
    // R9: data input is always pass-through
    bus_read(u, 2'd0, v, n);
    chk(n == 3, "R9 di latency", n, 3);
    for (int it = 0; it < 30; it++) begin
      d = 8'($urandom);
      lat[u] = 8'(2 + ($urandom % 13));
      bus_write(u, 2'd0, d, "R4");
      if ($urandom % 2 == 0) begin
        // R6: fresh task, old copies must not be used
        bus_read(u, 2'd2, v, n);
        chk(n == 3, "R6 stale status latency", n, 3);
        chk(v == 8'h00, "R6 status fresh", int'(v), 0);
      end
      if ($urandom % 3 == 0) bus_write(u, 2'd2, 8'($urandom), "R7");
      if ($urandom % 4 == 0 && it != 29) continue;
      repeat (int'(lat[u]) + 12) @(negedge clk);
      r0 = rdcnt[u];
      bus_read(u, 2'd2, v, n);
      lat_sum[u] += n;
      chk(n == hit_n, (u == 0) ? "R2 status latency" : "R8 status latency", n, hit_n);
      chk(v == 8'h01, "R5 status done", int'(v), 1);
      bus_read(u, 2'd1, v, n);
      lat_sum[u] += n;
      chk(n == hit_n, (u == 0) ? "R2 result latency" : "R8 result latency", n, hit_n);
      chk(v == exp_result(d), "R5 result data", int'(v), int'(exp_result(d)));
      chk(rdcnt[u] - r0 == ((u == 0) ? 0 : 2), (u == 0) ? "R2 no core read" : "R8 core reads",
          rdcnt[u] - r0, (u == 0) ? 0 : 2);
      if ($urandom % 3 == 0) begin
        bus_read(u, 2'd0, v, n);
        chk(n == 3 && v == d, "R9 di readback", int'(v), int'(d));
      end
    end
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    for (int u = 0; u < 2; u++) begin
      b_addr[u] = '0; b_wdata[u] = '0; b_rd[u] = 1'b0; b_wr[u] = 1'b0;
      lat[u] = 8'd2; rdcnt[u] = 0; lat_sum[u] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int u = 0; u < 2; u++)
      chk(!b_ack[u] && !b_wait[u] && !c_rd[u] && !c_wr[u], "R1 reset outputs",
          int'({b_ack[u], b_wait[u], c_rd[u], c_wr[u]}), 0);
    run_unit(0);
    run_unit(1);
    chk(lat_sum[0] < lat_sum[1], "R8 prefetch saves cycles", lat_sum[0], lat_sum[1]);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule